// File: doc/BRIEF.md
# USART Synchronous Clock Output Generator

This block drives the clock pin of a serial transmitter running as a synchronous master. It emits one clock pulse for each data bit of a frame. The pin stays at its idle level during the start bit, during the stop bit and between frames. The idle level and the capture edge are configurable, and the pulse of the final data bit can be left out. A baud generator supplies a one-cycle pulse at every half-bit boundary. The transmit shifter supplies a frame-start pulse. The block keeps its own count of bit slots and half periods.

The four configuration inputs (idle level, capture phase, last-pulse enable, nine-bit frame) are copied into internal registers only while transmit enable is low. Changing them while the transmitter is enabled therefore has no effect. The block also gives the shifter a one-cycle strobe at each data-bit boundary, which is half a bit period before the capture edge in phase 0. Both outputs are registered: each change appears one clock after the clock edge that samples the half-bit pulse causing it.

Top module: `usart_sync_clkgen`

## Requirements
- R1: While no frame is active, `sck` equals the latched idle level (`cfg_pol`: 0 = low, 1 = high). While `tx_en` is low, `sck` follows `cfg_pol` with a one-cycle delay.
- R2: With phase 0 (`cfg_pha`=0), a pulsed data bit holds `sck` at idle for its first half and at the opposite level for its second half. The edges therefore fall at mid-bit and at the bit end.
- R3: With phase 1 (`cfg_pha`=1), a pulsed data bit holds `sck` at the opposite level for its first half and at idle for its second half. The edges therefore fall at the bit start and at mid-bit.
- R4: With `cfg_last`=0, the last data bit gets no pulse, and a frame shows 2·(N−1) pin transitions, where N is the data-bit count.
- R5: With `cfg_last`=1, every data bit gets a pulse, and a frame shows 2·N pin transitions.
- R6: Configuration inputs are sampled only while `tx_en` is low. Changing them while `tx_en` is high does not alter the frame in progress or the idle level.
- R7: `sck` stays at idle during the start bit (half periods 0–1), during the stop bit (half periods 2N+2 to 2N+3) and between frames.
- R8: `shift_stb` is high for exactly one cycle, the cycle after the half-bit pulse that opens data bit k (half period 2k, for 1 ≤ k ≤ N), and is low at all other times.
- R9: The data-bit count N is 8 when the latched `cfg_nine` is 0 and 9 when it is 1. Each frame lasts 2·(N+2) half periods, and the last-bit rule applies to bit N.
- R10: `frame_go` starts a frame only when `tx_en` is high and no frame is active. Dropping `tx_en` aborts a frame, and `sck` returns to idle on the next cycle.
- R11: A synchronous active-low reset sets `sck` to `cfg_pol`, clears `shift_stb` and clears the bit-slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmitter enable; configuration is latched while it is low |
| frame_go | input | 1 | One-cycle pulse from the shifter that begins a frame (start bit) |
| half_tick | input | 1 | One-cycle pulse at every half-bit boundary |
| cfg_pol | input | 1 | Idle level of the clock pin |
| cfg_pha | input | 1 | Capture edge: 0 = first edge, 1 = second edge |
| cfg_last | input | 1 | 1 = pulse on the last data bit as well |
| cfg_nine | input | 1 | 1 = nine data bits, 0 = eight |
| sck | output | 1 | Clock pin level |
| shift_stb | output | 1 | Data-change strobe to the shifter |

## Verification
The hardest case to reach is a frame whose configuration inputs change while the frame is running. The same applies to a `frame_go` pulse that arrives mid-frame, since a correct design shows neither at the pins. The stimulus randomises all four configuration inputs, and occasionally pulses `frame_go`, in the gap cycles between half-bit pulses of a running frame. It then compares every cycle of `sck` and `shift_stb` against the configuration that was latched before `tx_en` rose. The gaps between half-bit pulses are random, including back-to-back pulses, and a directed abort drops `tx_en` in the middle of a pulsed data bit.

// File: rtl/usart_sync_clkgen.sv
module usart_sync_clkgen #(
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic frame_go,
  input  logic half_tick,
  input  logic cfg_pol,
  input  logic cfg_pha,
  input  logic cfg_last,
  input  logic cfg_nine,
  output logic sck,
  output logic shift_stb
);
  localparam int SW = $clog2(LONG_LEN + 2);

  logic          pol_l, pha_l, last_l, nine_l;
  logic          act_q, half_q, sck_q, stb_q;
  logic [SW-1:0] slot_q;
  logic          act_d, half_d, pulse_d, sck_d, stb_d;
  logic [SW-1:0] slot_d;

  wire [SW-1:0] nbits     = nine_l ? SW'(LONG_LEN) : SW'(SHORT_LEN);
  wire [SW-1:0] stop_slot = nbits + SW'(1);
  wire          pol_n     = tx_en ? pol_l : cfg_pol;

  always_comb begin
    act_d  = act_q;
    half_d = half_q;
    slot_d = slot_q;
    if (!tx_en) begin
      act_d  = 1'b0;
      half_d = 1'b0;
      slot_d = '0;
    end else if (!act_q) begin
      if (frame_go) begin
        act_d  = 1'b1;
        half_d = 1'b0;
        slot_d = '0;
      end
    end else if (half_tick) begin
      if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (slot_q == stop_slot) begin
          act_d  = 1'b0;
          slot_d = '0;
        end else begin
          slot_d = slot_q + SW'(1);
        end
      end
    end
  end

  assign pulse_d = act_d && (slot_d != '0) && (slot_d <= nbits) &&
                   (last_l || (slot_d != nbits));
  assign sck_d   = pol_n ^ (pulse_d && (half_d ^ pha_l));
  assign stb_d   = tx_en && act_q && half_tick && half_q && (slot_q < nbits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_l  <= cfg_pol;
      pha_l  <= cfg_pha;
      last_l <= cfg_last;
      nine_l <= cfg_nine;
      act_q  <= 1'b0;
      half_q <= 1'b0;
      slot_q <= '0;
      sck_q  <= cfg_pol;
      stb_q  <= 1'b0;
    end else begin
      if (!tx_en) begin
        pol_l  <= cfg_pol;
        pha_l  <= cfg_pha;
        last_l <= cfg_last;
        nine_l <= cfg_nine;
      end
      act_q  <= act_d;
      half_q <= half_d;
      slot_q <= slot_d;
      sck_q  <= sck_d;
      stb_q  <= stb_d;
    end
  end

  assign sck       = sck_q;
  assign shift_stb = stb_q;
endmodule

// File: rtl/usart_sync_clkgen_chk.sv
module usart_sync_clkgen_chk #(
  parameter int SHORT_LEN = 8,
  parameter int LONG_LEN  = 9,
  parameter int SW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          half_tick,
  input logic          cfg_pol,
  input logic          sck,
  input logic          shift_stb,
  input logic          pol_l,
  input logic          pha_l,
  input logic          last_l,
  input logic          nine_l,
  input logic          act_q,
  input logic          half_q,
  input logic [SW-1:0] slot_q
);
  logic [SW-1:0] nb;
  assign nb = nine_l ? SW'(LONG_LEN) : SW'(SHORT_LEN);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (sck == $past(cfg_pol)));  // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> $stable({pol_l, pha_l, last_l, nine_l}));  // R6
  AST_IDLE_OUTSIDE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q || slot_q == '0 || slot_q > nb) |-> (sck == pol_l));  // R7
  AST_LAST_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && slot_q == nb && !last_l) |-> (sck == pol_l));  // R4
  AST_STB_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (act_q && !half_q && slot_q != '0 && slot_q <= nb));  // R8
  AST_STB_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> $past(half_tick));  // R8
  AST_ABORT_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !act_q);  // R10
endmodule

bind usart_sync_clkgen usart_sync_clkgen_chk #(
  .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .half_tick(half_tick),
  .cfg_pol(cfg_pol), .sck(sck), .shift_stb(shift_stb),
  .pol_l(pol_l), .pha_l(pha_l), .last_l(last_l), .nine_l(nine_l),
  .act_q(act_q), .half_q(half_q), .slot_q(slot_q)
);

// File: tb/usart_sync_clkgen_tb.sv
`timescale 1ns/1ps
module usart_sync_clkgen_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tx_en = 1'b0, frame_go = 1'b0, half_tick = 1'b0;
  logic cfg_pol = 1'b0, cfg_pha = 1'b0, cfg_last = 1'b0, cfg_nine = 1'b0;
  wire  sck, shift_stb;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  int  h, tog, stbs, n_cur;
  bit  f_pol, f_pha, f_last, prev_sck;

  usart_sync_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_go(frame_go),
    .half_tick(half_tick), .cfg_pol(cfg_pol), .cfg_pha(cfg_pha),
    .cfg_last(cfg_last), .cfg_nine(cfg_nine), .sck(sck), .shift_stb(shift_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_lvl(bit pol, bit pha, bit last, int n, int hp);
    int slot = hp / 2;
    bit sec  = (hp % 2) == 1;
    bit pulse = (slot >= 1) && (slot <= n) && (last || slot != n);
    return pol ^ (pulse && (sec != pha));
  endfunction

  function automatic string req_of(bit pha, bit last, int n, int hp);
    int slot = hp / 2;
    if (slot == 0 || slot > n) return "R7 start/stop idle";
    if (slot == n && !last)    return "R4 last pulse suppressed";
    return pha ? "R3 phase 1 level" : "R2 phase 0 level";
  endfunction

  task automatic sample(input bit after_tick);
    bit es;
    chk(req_of(f_pha, f_last, n_cur, h), sck, exp_lvl(f_pol, f_pha, f_last, n_cur, h));
    if (sck != prev_sck) tog++;
    prev_sck = sck;
    es = after_tick && (h % 2 == 0) && (h / 2 >= 1) && (h / 2 <= n_cur);
    chk("R8 strobe timing", shift_stb, es);
    if (shift_stb) stbs++;
  endtask

  task automatic scramble_cfg();
    cfg_pol  = 1'($urandom);
    cfg_pha  = 1'($urandom);
    cfg_last = 1'($urandom);
    cfg_nine = 1'($urandom);
  endtask

  task automatic run_frame(input bit pol, input bit pha, input bit last, input bit nine,
                           input bit scramble, input int maxgap);
    @(negedge clk);
    tx_en = 1'b0; cfg_pol = pol; cfg_pha = pha; cfg_last = last; cfg_nine = nine;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle level", sck, pol);
    f_pol = pol; f_pha = pha; f_last = last; n_cur = nine ? 9 : 8;
    tx_en = 1'b1;
    @(negedge clk);
    frame_go = 1'b1;
    if (scramble) scramble_cfg();
    @(negedge clk);
    frame_go = 1'b0;
    h = 0; tog = 0; stbs = 0; prev_sck = sck;
    sample(1'b0);
    for (int k = 0; k < 2 * (n_cur + 2); k++) begin
      int gap = $urandom_range(0, maxgap);
      for (int g = 0; g < gap; g++) begin
        if (scramble) begin
          scramble_cfg();
          if ($urandom_range(0, 3) == 0) frame_go = 1'b1;
        end
        @(negedge clk);
        frame_go = 1'b0;
        sample(1'b0);
      end
      half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0;
      h++;
      sample(1'b1);
    end
    chk(last ? "R5 edges per frame" : "R4 edges per frame", tog,
        last ? 2 * n_cur : 2 * (n_cur - 1));
    chk("R9 data bits per frame", stbs, n_cur);
    if (scramble) scramble_cfg();
    @(negedge clk);
    chk(scramble ? "R6 idle level frozen" : "R7 between frames", sck, pol);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R11: reset drives the idle level from cfg_pol
    rst_n = 1'b0; cfg_pol = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 reset sck high", sck, 1);
    chk("R11 reset strobe", shift_stb, 0);
    cfg_pol = 1'b0;
    @(negedge clk);
    chk("R11 reset sck low", sck, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: every polarity/phase/last/length combination
    for (int c = 0; c < 16; c++)
      run_frame(c[0], c[1], c[2], c[3], 1'b0, c % 3);

    // random frames with config and frame_go disturbed mid-frame (R6, R10)
    for (int r = 0; r < 40; r++)
      run_frame(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 4);

    // R10: abort mid-pulse, then frame_go with tx_en low is ignored
    run_frame(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    @(negedge clk);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    for (int k = 0; k < 3; k++) begin
      half_tick = 1'b1; @(negedge clk); half_tick = 1'b0;
    end
    chk("R10 pulse active before abort", sck, 0);
    tx_en = 1'b0; cfg_pol = 1'b1;
    @(negedge clk);
    chk("R10 abort returns idle", sck, 1);
    chk("R10 abort no strobe", shift_stb, 0);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    for (int k = 0; k < 6; k++) begin
      half_tick = 1'b1; @(negedge clk); half_tick = 1'b0;
      chk("R10 frame_go ignored when disabled", sck, 1);
      chk("R10 no strobe when disabled", shift_stb, 0);
    end
    cfg_pol = 1'b0;
    @(negedge clk);
    chk("R1 idle follows cfg while disabled", sck, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule